// File: doc/BRIEF.md
# Deferred-Retire Column Write Buffer

This block sits in the column datapath of a DRAM device and holds exactly one pending write. A write command aimed at this device stores a 16-byte data unit (nine bits per byte in the 18-bit organisation, so 144 bits) together with its bank number, column number and per-byte write enable mask. The stored entry is not sent to the sense-amp array when the write arrives. It is committed later, on a following column command that allows it.

A retire may happen on a no-op or a write column command, whichever device either one targets, and on a read aimed at another device. It is never issued during a read aimed at this device, because the internal data path is busy returning read data. When a retire takes place, the block raises a one-cycle strobe carrying the buffered bank, column, data and mask, and the external array model applies the masked write. A same-device read whose bank and column match the buffered entry raises a bypass flag, so the controller knows the array still holds stale data for that address. Internally the data unit is split into parallel lanes (two 72-bit halves by default), each storing its own share of the bytes and mask bits.

Top module: `wrbuf_defer`

## Requirements
- R1: After reset, `ret_vld` and `rd_hit` are 0 and the buffer is empty.
- R2: A column command with `col_vld`=1, `col_op`=1 (write) and `same_dev`=1 captures `col_bank`, `col_col`, `wr_data` and `wr_mask` into the buffer. If the buffer was empty, no retire follows that command.
- R3: With the buffer full, a command with `col_op`=0 (no-op) retires the entry on either device. `ret_vld` is 1 for the one cycle after the clock edge that sampled the command, with the stored bank, column, data and mask on the retire outputs. The buffer is then empty.
- R4: With the buffer full, a read (`col_op`=2) with `same_dev`=0 retires the entry.
- R5: A read with `same_dev`=1 never retires. The entry stays buffered.
- R6: A same-device write to a full buffer retires the old entry and captures the new one on the same edge.
- R7: A write with `same_dev`=0 retires a full buffer and captures nothing.
- R8: A command that would permit a retire, arriving while the buffer is empty, leaves `ret_vld` at 0.
- R9: `rd_hit` is 1 for one cycle after a same-device read whose bank and column both equal those of the buffered entry. Otherwise it is 0.
- R10: While `col_vld`=0, or with `col_op`=3 (reserved), neither capture nor retire happens.
- R11: `ret_mask` bit i belongs to byte i, which is `ret_data[i*9 +: 9]`. A mask bit of 1 enables that byte's write, and the mask is delivered exactly as captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| col_vld | input | 1 | A column command is present this cycle |
| col_op | input | 2 | 0 no-op, 1 write, 2 read, 3 reserved |
| same_dev | input | 1 | The command targets this device |
| col_bank | input | BANK_W | Bank of the command |
| col_col | input | COL_W | Column unit of the command |
| wr_data | input | DATA_W | Write data unit |
| wr_mask | input | BYTES | Per-byte write enable, 1 = write |
| ret_vld | output | 1 | Retire strobe |
| ret_bank | output | BANK_W | Retired bank |
| ret_col | output | COL_W | Retired column unit |
| ret_data | output | DATA_W | Retired data unit |
| ret_mask | output | BYTES | Retired byte enables |
| rd_hit | output | 1 | A same-device read matched the buffered entry |

## Verification
A stale or lost occupancy flag shows at the ports within one command. The next permitted retire either fires with nothing buffered or fails to fire, and `ret_vld` differs from the model one cycle after that command. A corrupted stored field stays hidden until the entry retires, where `ret_bank`, `ret_col`, `ret_data` or `ret_mask` disagree. A matching same-device read shows a wrong bank or column earlier through `rd_hit`. The bench therefore issues a retire soon after each capture, and it mixes a long run of commands so that no corruption can stay buffered for long.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
   typedef enum logic [1:0] {
      COP_NOP = 2'd0,
      COP_WR  = 2'd1,
      COP_RD  = 2'd2,
      COP_RSV = 2'd3
   } colop_e;
endpackage

// File: rtl/wrbuf_policy.sv
module wrbuf_policy
   import wrbuf_pkg::*;
(
   input  logic       col_vld,
   input  logic [1:0] col_op,
   input  logic       same_dev,
   input  logic       held,
   output logic       capture,
   output logic       retire,
   output logic       rd_same
);
   colop_e op;
   logic   is_wr, is_rd, is_nop;

   always_comb begin
      op      = colop_e'(col_op);
      is_wr   = col_vld && (op == COP_WR);
      is_rd   = col_vld && (op == COP_RD);
      is_nop  = col_vld && (op == COP_NOP);
      capture = is_wr && same_dev;
      // same-device read keeps the internal path busy: no retire
      retire  = held && (is_wr || is_nop || (is_rd && !same_dev));
      rd_same = is_rd && same_dev;
   end
endmodule

// File: rtl/wrbuf_tag.sv
module wrbuf_tag #(
   parameter int BANK_W = 5,
   parameter int COL_W  = 7
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              capture,
   input  logic              retire,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [COL_W-1:0]  in_col,
   output logic              held_q,
   output logic [BANK_W-1:0] bank_q,
   output logic [COL_W-1:0]  col_q,
   output logic              match
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         held_q <= 1'b0;
         bank_q <= '0;
         col_q  <= '0;
      end else if (capture) begin
         held_q <= 1'b1;
         bank_q <= in_bank;
         col_q  <= in_col;
      end else if (retire) begin
         held_q <= 1'b0;
      end
   end

   assign match = held_q && (bank_q == in_bank) && (col_q == in_col);
endmodule

// File: rtl/wrbuf_lane.sv
module wrbuf_lane #(
   parameter int LANE_BYTES = 8,
   parameter int BYTE_W     = 9,
   localparam int LANE_W    = LANE_BYTES * BYTE_W
) (
   input  logic                  clk,
   input  logic                  arst_n,
   input  logic                  capture,
   input  logic [LANE_W-1:0]     din,
   input  logic [LANE_BYTES-1:0] min,
   output logic [LANE_W-1:0]     dq,
   output logic [LANE_BYTES-1:0] mq
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         dq <= '0;
         mq <= '0;
      end else if (capture) begin
         dq <= din;
         mq <= min;
      end
   end
endmodule

// File: rtl/wrbuf_defer.sv
module wrbuf_defer #(
   parameter int BANK_W = 5,
   parameter int COL_W  = 7,
   parameter int BYTES  = 16,
   parameter bit WIDE   = 1'b1,
   parameter int LANES  = 2,
   localparam int BYTE_W     = WIDE ? 9 : 8,
   localparam int DATA_W     = BYTES * BYTE_W,
   localparam int LANE_BYTES = BYTES / LANES,
   localparam int LANE_W     = LANE_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              col_vld,
   input  logic [1:0]        col_op,
   input  logic              same_dev,
   input  logic [BANK_W-1:0] col_bank,
   input  logic [COL_W-1:0]  col_col,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BYTES-1:0]  wr_mask,
   output logic              ret_vld,
   output logic [BANK_W-1:0] ret_bank,
   output logic [COL_W-1:0]  ret_col,
   output logic [DATA_W-1:0] ret_data,
   output logic [BYTES-1:0]  ret_mask,
   output logic              rd_hit
);
   generate
      if (LANES < 1 || (BYTES % LANES) != 0)
         $error("wrbuf_defer: BYTES must split evenly over LANES");
      if (BANK_W < 1 || COL_W < 1)
         $error("wrbuf_defer: address widths must be positive");
   endgenerate

   logic              capture, retire, rd_same, match, held_q;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] data_q;
   logic [BYTES-1:0]  mask_q;

   wrbuf_policy u_policy (
      .col_vld (col_vld),
      .col_op  (col_op),
      .same_dev(same_dev),
      .held    (held_q),
      .capture (capture),
      .retire  (retire),
      .rd_same (rd_same)
   );

   wrbuf_tag #(.BANK_W(BANK_W), .COL_W(COL_W)) u_tag (
      .clk    (clk),
      .arst_n (arst_n),
      .capture(capture),
      .retire (retire),
      .in_bank(col_bank),
      .in_col (col_col),
      .held_q (held_q),
      .bank_q (bank_q),
      .col_q  (col_q),
      .match  (match)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wrbuf_lane #(.LANE_BYTES(LANE_BYTES), .BYTE_W(BYTE_W)) u_lane (
         .clk    (clk),
         .arst_n (arst_n),
         .capture(capture),
         .din    (wr_data[l*LANE_W +: LANE_W]),
         .min    (wr_mask[l*LANE_BYTES +: LANE_BYTES]),
         .dq     (data_q[l*LANE_W +: LANE_W]),
         .mq     (mask_q[l*LANE_BYTES +: LANE_BYTES])
      );
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         ret_vld  <= 1'b0;
         ret_bank <= '0;
         ret_col  <= '0;
         ret_data <= '0;
         ret_mask <= '0;
         rd_hit   <= 1'b0;
      end else begin
         ret_vld <= retire;
         rd_hit  <= rd_same && match;
         if (retire) begin
            ret_bank <= bank_q;
            ret_col  <= col_q;
            ret_data <= data_q;
            ret_mask <= mask_q;
         end
      end
   end
endmodule

// File: rtl/wrbuf_defer_chk.sv
module wrbuf_defer_chk #(
   parameter int BANK_W = 5
) (
   input logic              clk,
   input logic              arst_n,
   input logic              col_vld,
   input logic [1:0]        col_op,
   input logic              same_dev,
   input logic [BANK_W-1:0] col_bank,
   input logic              held_q,
   input logic [BANK_W-1:0] bank_q,
   input logic              ret_vld,
   input logic              rd_hit
);
   AST_SAME_RD_NO_RETIRE: assert property (@(posedge clk) disable iff (!arst_n)
      (col_vld && col_op == 2'd2 && same_dev) |=> !ret_vld); // R5
   AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!arst_n)
      !held_q |=> !ret_vld); // R8
   AST_NOP_RETIRES: assert property (@(posedge clk) disable iff (!arst_n)
      (col_vld && col_op == 2'd0 && held_q) |=> (ret_vld && !held_q)); // R3
   AST_WR_CAPTURES: assert property (@(posedge clk) disable iff (!arst_n)
      (col_vld && col_op == 2'd1 && same_dev) |=> (held_q && bank_q == $past(col_bank))); // R2
   AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!arst_n)
      (!col_vld || col_op == 2'd3) |=> (!ret_vld && $stable(held_q))); // R10
   AST_HIT_NEEDS_SAME_RD: assert property (@(posedge clk) disable iff (!arst_n)
      rd_hit |-> $past(col_vld && col_op == 2'd2 && same_dev && held_q)); // R9
endmodule

bind wrbuf_defer wrbuf_defer_chk #(.BANK_W(BANK_W)) u_chk (
   .clk     (clk),
   .arst_n  (arst_n),
   .col_vld (col_vld),
   .col_op  (col_op),
   .same_dev(same_dev),
   .col_bank(col_bank),
   .held_q  (held_q),
   .bank_q  (bank_q),
   .ret_vld (ret_vld),
   .rd_hit  (rd_hit)
);

// File: tb/wrbuf_defer_tb.sv
`timescale 1ns/1ps
module wrbuf_defer_tb_top;
   localparam int BW = 5, CW = 7, NB = 16, DW = 144;

   logic          clk = 1'b0;
   logic          arst_n = 1'b0;
   logic          col_vld = 1'b0;
   logic [1:0]    col_op = 2'd0;
   logic          same_dev = 1'b0;
   logic [BW-1:0] col_bank = '0;
   logic [CW-1:0] col_col = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NB-1:0] wr_mask = '0;
   logic          ret_vld, rd_hit;
   logic [BW-1:0] ret_bank;
   logic [CW-1:0] ret_col;
   logic [DW-1:0] ret_data;
   logic [NB-1:0] ret_mask;

   int  n_run = 0, n_fail = 0;
   bit  done = 0;

   // behavioural reference: a queue holding at most one pending write
   logic [BW-1:0] q_bank[$];
   logic [CW-1:0] q_col[$];
   logic [DW-1:0] q_data[$];
   logic [NB-1:0] q_mask[$];
   logic          e_ret, e_hit;
   logic [BW-1:0] e_bank;
   logic [CW-1:0] e_col;
   logic [DW-1:0] e_data;
   logic [NB-1:0] e_mask;

   always #10 clk = ~clk;

   wrbuf_defer dut_i (.*);

   function automatic logic [DW-1:0] mkdata(int s);
      logic [DW-1:0] v = '0;
      for (int k = 0; k < 5; k++)
         v = (v << 32) | DW'(32'(s * 32'h9E3779B1 + k * 32'h7F4A7C15));
      return v;
   endfunction

   task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      bit permit;
      e_ret = 0;
      e_hit = 0;
      if (col_vld && col_op != 2'd3) begin
         if (col_op == 2'd2 && same_dev && q_bank.size() != 0)
            e_hit = (q_bank[0] == col_bank) && (q_col[0] == col_col);
         permit = (col_op == 2'd1) || (col_op == 2'd0) || (col_op == 2'd2 && !same_dev);
         if (permit && q_bank.size() != 0) begin
            e_ret  = 1;
            e_bank = q_bank.pop_front();
            e_col  = q_col.pop_front();
            e_data = q_data.pop_front();
            e_mask = q_mask.pop_front();
         end
         if (col_op == 2'd1 && same_dev) begin
            q_bank.push_back(col_bank);
            q_col.push_back(col_col);
            q_data.push_back(wr_data);
            q_mask.push_back(wr_mask);
         end
      end
   endtask

   task automatic step(bit v, logic [1:0] op, bit sd, int bank, int col, int seed,
                       logic [NB-1:0] m, string tag);
      col_vld  = v;
      col_op   = op;
      same_dev = sd;
      col_bank = BW'(bank);
      col_col  = CW'(col);
      wr_data  = mkdata(seed);
      wr_mask  = m;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(tag, "ret_vld", DW'(ret_vld), DW'(e_ret));
      chk(tag, "rd_hit", DW'(rd_hit), DW'(e_hit));
      if (e_ret) begin
         chk(tag, "ret_bank", DW'(ret_bank), DW'(e_bank));
         chk(tag, "ret_col", DW'(ret_col), DW'(e_col));
         chk(tag, "ret_data", ret_data, e_data);
         chk(tag, "ret_mask", DW'(ret_mask), DW'(e_mask));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "ret_vld", DW'(ret_vld), '0);
      chk("R1", "rd_hit", DW'(rd_hit), '0);
      arst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ret_vld", DW'(ret_vld), '0);
      step(1, 2'd0, 1, 0, 0, 1, 16'hFFFF, "R8");       // empty, no retire
      step(1, 2'd1, 1, 3, 17, 2, 16'hA5C3, "R2");      // capture A
      step(1, 2'd2, 1, 3, 17, 3, 16'h0000, "R9");      // hit, R5 blocks
      step(1, 2'd2, 1, 3, 18, 4, 16'h0000, "R5");      // no hit, still blocked
      step(0, 2'd1, 1, 9, 9, 5, 16'hFFFF, "R10");      // idle write ignored
      step(1, 2'd3, 0, 9, 9, 6, 16'hFFFF, "R10");      // reserved op ignored
      step(1, 2'd0, 0, 0, 0, 7, 16'h0000, "R3");       // retire A on NOP
      step(1, 2'd0, 1, 0, 0, 8, 16'h0000, "R8");
      step(1, 2'd1, 1, 31, 127, 9, 16'h0001, "R2");    // capture B
      step(1, 2'd1, 1, 1, 0, 10, 16'h8000, "R6");      // retire B, capture C
      step(1, 2'd2, 0, 1, 0, 11, 16'h0000, "R4");      // retire C on foreign read
      step(1, 2'd1, 1, 7, 64, 12, 16'h3C3C, "R2");     // capture D
      step(1, 2'd1, 0, 8, 65, 13, 16'hFFFF, "R7");     // retire D, no capture
      step(1, 2'd0, 1, 0, 0, 14, 16'h0000, "R7");      // buffer must be empty
      step(1, 2'd1, 1, 2, 5, 15, 16'h5A5A, "R11");
      step(1, 2'd1, 1, 2, 6, 16, 16'h0F0F, "R11");     // mask of first checked
      step(1, 2'd0, 1, 0, 0, 17, 16'h0000, "R3");
      for (int i = 0; i < 400; i++)
         step(($urandom % 8) != 0, 2'($urandom), 1'($urandom), $urandom % 4, $urandom % 4,
              100 + i, 16'($urandom), "R2/R3/R4/R5/R6/R9");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule